// File: doc/BRIEF.md
# Local-Bus DMA Read Responder with Frame-Count Interrupt

This block sits on the FPGA side of a 32-bit local bus, nominally clocked at 66 MHz, through which a PCI bridge pulls buffered frame data into host memory by DMA. It keeps a running count of complete frames waiting in the frame buffer. When that count reaches a frame threshold set by the host, it raises an interrupt request. The host answers by starting a DMA. The bridge then requests the local bus with a hold signal, and the block grants it with a hold acknowledge.

While the bus is granted, the block streams words from the buffer's read port onto the local data bus. Ready and the buffer read enable are always asserted together. Ready is held off for as long as the buffer has nothing to give. The bridge marks the final word with a last-beat signal, and after that word no further ready is given. When the bridge releases hold, the acknowledge is withdrawn and the block goes back to idle.

Words read out are counted. A frame is taken off the pending count only once all of its words have left the buffer, so a frame may be split over several bursts. The interrupt re-arms after each transfer. The bridge's active-low local reset returns everything to idle at once.

Top module: `lbus_dma_resp`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, irq, hold_ack, ready and fifo_rd are low and the pending frame count is zero.
- R2: With the block idle and bus_hold low, irq goes high one clock after the registered pending frame count first satisfies count >= thresh_frames. A threshold of 0 never raises irq.
- R3: When bus_hold is high in idle, hold_ack is high after the next clock edge and irq is low from that same edge. hold_ack is never high unless bus_hold was high on the previous clock.
- R4: While hold_ack is high and no last beat has yet been taken, ready and fifo_rd are both high exactly when fifo_empty is low. Each such cycle is one beat, and ld carries fifo_data.
- R5: A beat never happens while fifo_empty is high. The block inserts wait states, with ready low, until data is present.
- R6: After a beat taken with last_beat high, ready and fifo_rd stay low until hold is released, even if the buffer holds data.
- R7: If bus_hold is low while hold_ack is high, hold_ack is low after the next clock edge.
- R8: The pending frame count drops by one only on the beat that completes a frame of WORDS_PER_FRAME words. Partial frames do not change it, and irq re-arms against the remaining count.
- R9: A frame_done pulse on the same clock as a frame-completing beat leaves the pending count unchanged.
- R10: Asserting rst_n low in the middle of a transfer drops hold_ack and ready at once, and clears the pending frame count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Active-low local reset from the bridge, asynchronous |
| frame_done | input | 1 | One-cycle pulse: a complete frame has entered the buffer |
| thresh_frames | input | FRAME_W | Host-set interrupt threshold in frames |
| irq | output | 1 | Interrupt request to the bridge |
| bus_hold | input | 1 | Bridge requests the local bus |
| hold_ack | output | 1 | Bus grant to the bridge |
| last_beat | input | 1 | Bridge marks the current beat as the final word |
| ready | output | 1 | Data valid on ld this cycle |
| fifo_empty | input | 1 | Buffer read port has no word |
| fifo_rd | output | 1 | Buffer read enable (show-ahead pop) |
| fifo_data | input | DATA_W | Word at the head of the buffer |
| ld | output | DATA_W | Local data bus |

## Verification
The bench builds the block with WORDS_PER_FRAME = 4 and FRAME_W = 4. This makes bursts of a few words long enough to complete a frame, to split a second frame across two bursts, and to line up a frame-completing beat with an incoming frame_done pulse. The pending count has no port of its own, so the bench reads it back by moving thresh_frames and watching irq settle. A single forced-empty cycle in the middle of a burst covers the wait-state path.

// File: rtl/lbus_dma_pkg.sv
package lbus_dma_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_XFER  = 2'd1,
        BUS_DRAIN = 2'd2
    } bus_state_e;
endpackage

// File: rtl/lbus_frame_tally.sv
module lbus_frame_tally #(
    parameter int FRAME_W         = 4,
    parameter int WORDS_PER_FRAME = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_in,
    input  logic               beat,
    input  logic               idle,
    input  logic               hold_req,
    input  logic [FRAME_W-1:0] thresh,
    output logic               irq
);
    localparam int WW = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1;
    localparam logic [WW-1:0]      LAST_WORD = WW'(WORDS_PER_FRAME - 1);
    localparam logic [FRAME_W-1:0] MAX_FR    = '1;

    typedef struct packed {
        logic [FRAME_W-1:0] frames;
        logic [WW-1:0]      words;
        logic               irq;
    } tally_t;

    tally_t tl_d, tl_q;
    logic   frame_end;

    always_comb begin
        tl_d      = tl_q;
        frame_end = beat && (tl_q.words == LAST_WORD);
        if (beat) begin
            tl_d.words = frame_end ? '0 : tl_q.words + 1'b1;
        end
        case ({frame_in, frame_end})
            2'b10:   if (tl_q.frames != MAX_FR) tl_d.frames = tl_q.frames + 1'b1;
            2'b01:   if (tl_q.frames != '0)     tl_d.frames = tl_q.frames - 1'b1;
            default: tl_d.frames = tl_q.frames;
        endcase
        tl_d.irq = idle && !hold_req && (thresh != '0) && (tl_q.frames >= thresh);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tl_q <= '0;
        else        tl_q <= tl_d;
    end

    assign irq = tl_q.irq;
endmodule

// File: rtl/lbus_bus_fsm.sv
module lbus_bus_fsm
    import lbus_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    input  logic last_beat,
    input  logic fifo_empty,
    output logic hold_ack,
    output logic ready,
    output logic idle
);
    typedef struct packed {
        bus_state_e st;
    } fsm_t;

    fsm_t fs_d, fs_q;

    always_comb begin
        fs_d  = fs_q;
        ready = (fs_q.st == BUS_XFER) && !fifo_empty;
        case (fs_q.st)
            BUS_IDLE:  if (hold_req) fs_d.st = BUS_XFER;
            BUS_XFER: begin
                if (!hold_req)               fs_d.st = BUS_IDLE;
                else if (last_beat && ready) fs_d.st = BUS_DRAIN;
            end
            BUS_DRAIN: if (!hold_req) fs_d.st = BUS_IDLE;
            default:   fs_d.st = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '{st: BUS_IDLE};
        else        fs_q <= fs_d;
    end

    assign hold_ack = (fs_q.st != BUS_IDLE);
    assign idle     = (fs_q.st == BUS_IDLE);
endmodule

// File: rtl/lbus_dma_resp.sv
module lbus_dma_resp #(
    parameter int DATA_W          = 32,
    parameter int FRAME_W         = 4,
    parameter int WORDS_PER_FRAME = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_done,
    input  logic [FRAME_W-1:0] thresh_frames,
    output logic               irq,
    input  logic               bus_hold,
    output logic               hold_ack,
    input  logic               last_beat,
    output logic               ready,
    input  logic               fifo_empty,
    output logic               fifo_rd,
    input  logic [DATA_W-1:0]  fifo_data,
    output logic [DATA_W-1:0]  ld
);
    logic idle_w;
    logic ready_w;

    lbus_bus_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_req   (bus_hold),
        .last_beat  (last_beat),
        .fifo_empty (fifo_empty),
        .hold_ack   (hold_ack),
        .ready      (ready_w),
        .idle       (idle_w)
    );

    lbus_frame_tally #(
        .FRAME_W         (FRAME_W),
        .WORDS_PER_FRAME (WORDS_PER_FRAME)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_in (frame_done),
        .beat     (ready_w),
        .idle     (idle_w),
        .hold_req (bus_hold),
        .thresh   (thresh_frames),
        .irq      (irq)
    );

    assign ready   = ready_w;
    assign fifo_rd = ready_w;
    assign ld      = ready_w ? fifo_data : '0;
endmodule

// File: rtl/lbus_dma_resp_chk.sv
module lbus_dma_resp_chk (
    input logic clk,
    input logic rst_n,
    input logic irq,
    input logic bus_hold,
    input logic hold_ack,
    input logic last_beat,
    input logic ready,
    input logic fifo_empty,
    input logic fifo_rd
);
    // R4
    ready_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> hold_ack);

    // R5
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    // R6
    quiet_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && ready && bus_hold) |=> !ready);

    // R3
    ack_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> $past(bus_hold));

    // R3
    irq_off_in_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !hold_ack);

    // R7
    release_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_hold && hold_ack) |=> !hold_ack);
endmodule

bind lbus_dma_resp lbus_dma_resp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .bus_hold   (bus_hold),
    .hold_ack   (hold_ack),
    .last_beat  (last_beat),
    .ready      (ready),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd)
);

// File: tb/lbus_dma_resp_tb.sv
module lbus_dma_resp_tb;
    localparam int DW  = 32;
    localparam int FW  = 4;
    localparam int WPF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_done = 1'b0;
    logic [FW-1:0] thresh_frames = '0;
    logic          irq;
    logic          bus_hold = 1'b0;
    logic          hold_ack;
    logic          last_beat = 1'b0;
    logic          ready;
    logic          fifo_empty;
    logic          fifo_rd;
    logic [DW-1:0] fifo_data;
    logic [DW-1:0] ld;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] fmem [64];
    int  wp = 0;
    int  rp = 0;
    int  exp_idx = 0;
    logic stall = 1'b0;

    always #4 clk = ~clk;

    assign fifo_empty = (wp == rp) || stall;
    assign fifo_data  = fmem[rp % 64];

    always @(posedge clk) if (fifo_rd) rp <= rp + 1;

    lbus_dma_resp #(.DATA_W(DW), .FRAME_W(FW), .WORDS_PER_FRAME(WPF)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .thresh_frames(thresh_frames), .irq(irq), .bus_hold(bus_hold),
        .hold_ack(hold_ack), .last_beat(last_beat), .ready(ready),
        .fifo_empty(fifo_empty), .fifo_rd(fifo_rd), .fifo_data(fifo_data), .ld(ld)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_words(input int n);
        for (int i = 0; i < n; i++) begin
            fmem[wp % 64] = 32'hC0DE_0000 + DW'(wp);
            wp++;
        end
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_done = 1'b1;
        @(negedge clk) frame_done = 1'b0;
    endtask

    task automatic probe(input int th, input bit exp_irq, input string req);
        @(negedge clk) thresh_frames = FW'(th);
        @(negedge clk);
        @(negedge clk);
        #1 chk(irq == exp_irq, req, irq, exp_irq);
    endtask

    task automatic run_burst(input int n, input int stall_cyc, input int fd_cyc);
        int beats = 0;
        int cyc = 0;
        @(negedge clk) bus_hold = 1'b1;
        while (beats < n && cyc < 50) begin
            @(negedge clk);
            stall      = (cyc == stall_cyc);
            frame_done = (cyc == fd_cyc);
            last_beat  = (beats == n - 1);
            #1;
            if (cyc == 0) begin
                chk(hold_ack == 1'b1, "R3 hold_ack after hold", hold_ack, 1);
                chk(irq == 1'b0, "R3 irq cleared on hold", irq, 0);
            end
            if (stall) begin
                chk(ready == 1'b0 && fifo_rd == 1'b0, "R5 wait state on empty", ready, 0);
            end else begin
                chk(ready == 1'b1 && fifo_rd == 1'b1, "R4 ready with read enable", ready, 1);
                chk(ld == 32'hC0DE_0000 + DW'(exp_idx), "R4 data on bus", ld,
                    32'hC0DE_0000 + DW'(exp_idx));
                exp_idx++;
                beats++;
            end
            cyc++;
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            stall = 1'b0; frame_done = 1'b0; last_beat = 1'b0;
            #1 chk(ready == 1'b0 && hold_ack == 1'b1, "R6 no ready after last beat", ready, 0);
        end
        bus_hold = 1'b0;
        @(negedge clk);
        #1 chk(hold_ack == 1'b0, "R7 hold_ack drops after hold release", hold_ack, 0);
    endtask

    // R1: reset state
    task automatic t_reset();
        #1 chk(irq == 0 && hold_ack == 0 && ready == 0 && fifo_rd == 0,
               "R1 outputs low in reset", {irq, hold_ack, ready, fifo_rd}, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk(irq == 0 && hold_ack == 0 && ready == 0, "R1 outputs low after reset",
               {irq, hold_ack, ready}, 0);
        probe(1, 1'b0, "R1 frame count zero");
    endtask

    // R2: threshold interrupt
    task automatic t_irq();
        thresh_frames = FW'(2);
        pulse_frame();
        @(negedge clk);
        #1 chk(irq == 0, "R2 irq low below threshold", irq, 0);
        frame_done = 1'b1;
        @(negedge clk) frame_done = 1'b0;
        #1 chk(irq == 0, "R2 irq not yet (count just registered)", irq, 0);
        @(negedge clk);
        #1 chk(irq == 1, "R2 irq one clock after count reaches threshold", irq, 1);
        probe(0, 1'b0, "R2 zero threshold disables irq");
        probe(2, 1'b1, "R2 irq back with threshold 2");
    endtask

    initial begin : main
        t_reset();
        t_irq();
        push_words(8);
        // R4 R5 R6 R7: six words, one wait state, completes frame one plus two words
        run_burst(6, 2, -1);
        // R8: count now 1
        probe(1, 1'b1, "R8 irq re-arms with one frame left");
        probe(2, 1'b0, "R8 count decremented by exactly one");
        // R9: finish second frame while a new frame arrives
        probe(1, 1'b1, "R8 irq set before second burst");
        run_burst(2, -1, 1);
        probe(1, 1'b1, "R9 simultaneous add and remove keeps count");
        probe(2, 1'b0, "R9 count not raised");
        // R10: reset during a transfer
        push_words(2);
        @(negedge clk) bus_hold = 1'b1;
        @(negedge clk);
        #1 chk(hold_ack == 1 && ready == 1, "R10 transfer in progress", hold_ack, 1);
        rst_n = 1'b0;
        #1 chk(hold_ack == 0 && ready == 0, "R10 reset drops grant at once", hold_ack, 0);
        bus_hold = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        probe(1, 1'b0, "R10 frame count cleared by reset");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule